// File: doc/BRIEF.md
# Flash command interface controller

This block models the command state machine of a small byte-wide flash memory. A host talks to it through active-low chip-enable, write-enable and output-enable strobes, an address bus and an 8-bit data bus. All of these are sampled on the block clock. Writes are decoded as unlock and command sequences that start timed program and erase operations on an internal register array. While an operation runs, reads return a status byte instead of array data, so the host can poll for completion.

The array depth is `2**ADDR_W` bytes. The default of 11 address bits keeps elaboration small, and a setting of 18 gives the full 256 KB part. The array is cut into seven sectors, and each sector has a protection flag input. The block offers several ways to write and clear the array: normal four-write programming, a two-write bypass mode, multi-sector erase with a collection window, whole-array erase, and erase suspend and resume. Programming can only clear bits. The program time and the length of the sector-collection window are parameters. An erase takes two passes over the array: a pass that writes zero to every selected byte, then a pass that writes all ones.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF. The block is in array-read mode, so a read (ce_n and oe_n low, we_n high) drives the addressed byte on dq_out with dq_oe high.
- R2: A bus write is taken when we_n rises while ce_n is low, using the address and data present in the cycle before. The writes AA@0x555, 55@0x2AA, A0@0x555, then data@address program that byte to the bitwise AND of its old value and the data. Programming never turns a 0 into a 1.
- R3: While a program, erase or sector-collection window is active, every read returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, and is 0 during erase. Bit 6 inverts on each read start (a falling edge of oe_n with ce_n low). Bits 5..0 are zero. Once the operation ends, reads return array data.
- R4: A write that does not match the expected next step of a sequence, or a write of F0, returns the block to array-read mode with the array unchanged. Later writes that would only have made sense inside the broken sequence are then ignored.
- R5: The writes AA@0x555, 55@0x2AA, 20@0x555 enter bypass mode. In this mode, A0 at any address followed by data@address programs a byte. F0 leaves bypass mode, and after that a two-write program has no effect.
- R6: Sectors run from address 0 upward. Their sizes are 8, 8, 8, 4, 1, 1 and 2 units, where one unit is depth/32. The prefix AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, followed by 30 at any address in a sector, selects that sector for erase. Each further 30 written within ERASE_WIN cycles of the last one adds a sector and restarts the window. When the window expires, every selected sector becomes 0xFF and all other bytes keep their values.
- R7: The same five-write prefix followed by 10@0x555 erases every unprotected sector to 0xFF.
- R8: A program aimed at a protected sector is dropped and the block returns to read mode at once with no busy status. An erase leaves protected sectors unchanged.
- R9: Writing B0 during an erase suspends it. While suspended, reads of unselected sectors return array data and reads of selected sectors return 0x80. A program to an unselected sector runs and completes, while a program to a selected sector is ignored. Writing 30 resumes the erase, which then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; write is taken at its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data from the host |
| sect_prot | input | 7 | Per-sector protection flags, bit n for sector n |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | High while the block drives the data bus |

## Verification
The bench targets the edges of the sector map. Bytes on either side of each boundary next to an erased sector are checked afterwards, so a mis-sized sector shows up as a neighbour that was wrongly erased or left dirty. The polarity of the status byte is checked on two successive reads. A toggle bit tied to the clock instead of to read starts, or a bit 7 that is not inverted, gives equal or wrong values. Broken sequences, exit from bypass mode and programs to protected sectors are each followed by writes that must have no effect, which catches a decoder that keeps stale state. The suspend test programs the sector next to the one being erased and then tries to write into the selected sector. The sweep after resume exposes an erase that restarted, leaked across sectors or let a write through.

// File: rtl/fci_pkg.sv
// Package: shared state type, command codes and sector lookup for the
// flash command interface controller. Assumes the array is split into 32
// equal units addressed by the top five bits of a byte index.
package fci_pkg;

    localparam int N_SECT = 7;

    localparam logic [7:0] CMD_UNLK1   = 8'hAA;
    localparam logic [7:0] CMD_UNLK2   = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERSETUP = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    typedef enum logic [3:0] {
        ST_READ,
        ST_U1,
        ST_U2,
        ST_PADDR,
        ST_E1,
        ST_E2,
        ST_E3,
        ST_EWIN,
        ST_PROG,
        ST_ERASE
    } fci_state_e;

    // Map the top five index bits (unit number 0..31) to a sector number.
    function automatic logic [2:0] sector_of(input logic [4:0] unit);
        if (unit < 5'd8)        return 3'd0;
        else if (unit < 5'd16)  return 3'd1;
        else if (unit < 5'd24)  return 3'd2;
        else if (unit < 5'd28)  return 3'd3;
        else if (unit == 5'd28) return 3'd4;
        else if (unit == 5'd29) return 3'd5;
        else                    return 3'd6;
    endfunction

endpackage

// File: rtl/fci_strobe.sv
// Strobe front end: registers the bus strobes, address and data once per
// clock and turns a rising we_n (with ce_n low) into a one-cycle write
// event, and a falling oe_n (with ce_n low) into a read-start event.
// Assumes the strobes are already synchronous to clk.
module fci_strobe #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_evt
);

    logic ce_q, we_q, oe_q;

    // Purpose: keep last-cycle copies of strobes, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b1;
            we_q    <= 1'b1;
            oe_q    <= 1'b1;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            ce_q    <= ce_n;
            we_q    <= we_n;
            oe_q    <= oe_n;
            wr_addr <= addr;
            wr_data <= dq_in;
        end
    end

    // Purpose: edge detection for write and read starts.
    always_comb begin
        wr_evt = we_n && !we_q && !ce_q;
        rd_evt = !oe_n && oe_q && !ce_n;
    end

endmodule

// File: rtl/fci_array.sv
// Register-array stand-in for the flash cells: one write port and two
// combinational read ports (host side and sequencer side). Every byte is
// forced to 0xFF by reset, modelling an erased part.
module fci_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd,
    input  logic [ADDR_W-1:0] ra0,
    output logic [7:0]        rd0,
    input  logic [ADDR_W-1:0] ra1,
    output logic [7:0]        rd1
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Purpose: erased state on reset, single-byte write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we) begin
            cells[wa] <= wd;
        end
    end

    // Purpose: asynchronous read ports.
    always_comb begin
        rd0 = cells[ra0];
        rd1 = cells[ra1];
    end

endmodule

// File: rtl/fci_seq.sv
// Command sequencer: decodes unlock and command writes, keeps the bypass
// and suspend flags, runs the timed program and the two-pass erase scan,
// and drives the array write port. Assumes one write event per cycle at
// most and static protection flags while an operation runs.
module fci_seq
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 8,
    parameter int ERASE_WIN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic [7:0]        mem_old,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wa,
    output logic [7:0]        mem_wd,
    output logic [ADDR_W-1:0] mem_ra,
    output logic              busy,
    output logic              erasing,
    output logic              susp,
    output logic [N_SECT-1:0] esel,
    output logic              tgt7
);

    localparam int PCW = $clog2(PROG_CYCLES + 1);
    localparam int WCW = $clog2(ERASE_WIN + 1);
    localparam logic [10:0] UNLK_A1 = 11'h555;
    localparam logic [10:0] UNLK_A2 = 11'h2AA;

    fci_state_e        state;
    logic              byp;
    logic [ADDR_W-1:0] pa;
    logic [7:0]        pd;
    logic [PCW-1:0]    pcnt;
    logic [WCW-1:0]    wcnt;
    logic [ADDR_W-1:0] scan;
    logic              phase;

    logic              at_a1, at_a2;
    logic [2:0]        wsec, ssec;
    logic [N_SECT-1:0] wsec_bit;

    // Purpose: decode address matches and sector numbers of write and scan.
    always_comb begin
        at_a1    = (wr_addr[10:0] == UNLK_A1);
        at_a2    = (wr_addr[10:0] == UNLK_A2);
        wsec     = sector_of(wr_addr[ADDR_W-1 -: 5]);
        ssec     = sector_of(scan[ADDR_W-1 -: 5]);
        wsec_bit = N_SECT'(1) << wsec;
    end

    // Purpose: array write port for the program commit and the erase scan.
    always_comb begin
        mem_ra  = pa;
        mem_we  = ((state == ST_PROG) && (pcnt == PCW'(1))) ||
                  ((state == ST_ERASE) && esel[ssec]);
        mem_wa  = (state == ST_PROG) ? pa : scan;
        mem_wd  = (state == ST_PROG) ? (mem_old & pd) : {8{phase}};
        busy    = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_EWIN);
        erasing = (state == ST_ERASE);
        tgt7    = (state == ST_PROG) ? pd[7] : 1'b1;
    end

    // Purpose: command state machine and operation counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
            byp   <= 1'b0;
            susp  <= 1'b0;
            esel  <= '0;
            pa    <= '0;
            pd    <= '0;
            pcnt  <= '0;
            wcnt  <= '0;
            scan  <= '0;
            phase <= 1'b0;
        end else begin
            case (state)
                ST_READ: if (wr_evt) begin
                    if (susp && wr_data == CMD_SECTOR) begin
                        susp  <= 1'b0;
                        state <= ST_ERASE;
                    end else if (byp) begin
                        if (wr_data == CMD_PROG)       state <= ST_PADDR;
                        else if (wr_data == CMD_RESET) byp   <= 1'b0;
                    end else if (wr_data == CMD_UNLK1 && at_a1) begin
                        state <= ST_U1;
                    end
                end
                ST_U1: if (wr_evt) begin
                    state <= (wr_data == CMD_UNLK2 && at_a2) ? ST_U2 : ST_READ;
                end
                ST_U2: if (wr_evt) begin
                    state <= ST_READ;
                    if (at_a1 && wr_data == CMD_PROG)
                        state <= ST_PADDR;
                    else if (at_a1 && wr_data == CMD_ERSETUP && !susp)
                        state <= ST_E1;
                    else if (at_a1 && wr_data == CMD_BYPASS && !susp)
                        byp <= 1'b1;
                end
                ST_PADDR: if (wr_evt) begin
                    if (sect_prot[wsec] || (susp && esel[wsec])) begin
                        state <= ST_READ;
                    end else begin
                        pa    <= wr_addr;
                        pd    <= wr_data;
                        pcnt  <= PCW'(PROG_CYCLES);
                        state <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    pcnt <= pcnt - PCW'(1);
                    if (pcnt == PCW'(1)) state <= ST_READ;
                end
                ST_E1: if (wr_evt) begin
                    state <= (wr_data == CMD_UNLK1 && at_a1) ? ST_E2 : ST_READ;
                end
                ST_E2: if (wr_evt) begin
                    state <= (wr_data == CMD_UNLK2 && at_a2) ? ST_E3 : ST_READ;
                end
                ST_E3: if (wr_evt) begin
                    if (wr_data == CMD_CHIP && at_a1) begin
                        esel  <= ~sect_prot;
                        scan  <= '0;
                        phase <= 1'b0;
                        state <= (&sect_prot) ? ST_READ : ST_ERASE;
                    end else if (wr_data == CMD_SECTOR) begin
                        esel  <= sect_prot[wsec] ? '0 : wsec_bit;
                        wcnt  <= WCW'(ERASE_WIN);
                        state <= ST_EWIN;
                    end else begin
                        state <= ST_READ;
                    end
                end
                ST_EWIN: begin
                    if (wr_evt) begin
                        if (wr_data == CMD_SECTOR) begin
                            if (!sect_prot[wsec]) esel <= esel | wsec_bit;
                            wcnt <= WCW'(ERASE_WIN);
                        end else begin
                            esel  <= '0;
                            state <= ST_READ;
                        end
                    end else if (wcnt == '0) begin
                        scan  <= '0;
                        phase <= 1'b0;
                        state <= (esel == '0) ? ST_READ : ST_ERASE;
                    end else begin
                        wcnt <= wcnt - WCW'(1);
                    end
                end
                ST_ERASE: begin
                    if (wr_evt && wr_data == CMD_SUSPEND) begin
                        susp  <= 1'b1;
                        state <= ST_READ;
                    end else begin
                        scan <= scan + ADDR_W'(1);
                        if (&scan) begin
                            if (!phase) begin
                                phase <= 1'b1;
                            end else begin
                                phase <= 1'b0;
                                esel  <= '0;
                                state <= ST_READ;
                            end
                        end
                    end
                end
                default: state <= ST_READ;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interface controller: strobe front end,
// sequencer, cell array, the read-data/status multiplexer and the toggle
// bit. Assumes ADDR_W >= 11 so the unlock addresses fit the bus.
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 8,
    parameter int ERASE_WIN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    input  logic [N_SECT-1:0] sect_prot,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    logic              wr_evt, rd_evt;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa, mem_ra;
    logic [7:0]        mem_wd, mem_old, arr_rd;
    logic              busy, erasing, susp, tgt7;
    logic [N_SECT-1:0] esel;
    logic              tog;
    logic [2:0]        rsec;

    fci_strobe #(.ADDR_W(ADDR_W)) strobe_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_evt(rd_evt)
    );

    fci_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_WIN(ERASE_WIN)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .wr_data(wr_data), .sect_prot(sect_prot), .mem_old(mem_old),
        .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd), .mem_ra(mem_ra),
        .busy(busy), .erasing(erasing), .susp(susp), .esel(esel), .tgt7(tgt7)
    );

    fci_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .ra0(addr), .rd0(arr_rd), .ra1(mem_ra), .rd1(mem_old)
    );

    // Purpose: toggle bit flips on each read start while an operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n)             tog <= 1'b0;
        else if (rd_evt && busy) tog <= ~tog;
    end

    // Purpose: choose status or array data for the host read path.
    always_comb begin
        rsec  = sector_of(addr[ADDR_W-1 -: 5]);
        dq_oe = !ce_n && !oe_n && we_n;
        if (busy)                   dq_out = {~tgt7, tog, 6'b0};
        else if (susp && esel[rsec]) dq_out = 8'h80;
        else                        dq_out = arr_rd;
    end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Checker for flash_cmd_ctrl: watches the array write port against the
// sequencer flags, the protection inputs and the read path. Bound to
// every instance of the top module.
module flash_cmd_ctrl_chk
    import fci_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_wa,
    input logic [7:0]        mem_wd,
    input logic [7:0]        mem_old,
    input logic              erasing,
    input logic              busy,
    input logic              susp,
    input logic [N_SECT-1:0] esel,
    input logic [N_SECT-1:0] sect_prot,
    input logic              dq_oe,
    input logic [7:0]        dq_out
);

    logic [2:0] wsec;
    always_comb wsec = sector_of(mem_wa[ADDR_W-1 -: 5]);

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !erasing) |-> ((mem_wd & ~mem_old) == 8'h00)); // R2
    AST_PROT_SECTOR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !sect_prot[wsec]); // R8
    AST_ERASE_IN_SELECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && erasing) |-> esel[wsec]); // R6
    AST_SUSP_SPARES_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && susp) |-> !esel[wsec]); // R9
    AST_SUSP_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && !busy) |-> !mem_we); // R9
    AST_ERASE_STATUS_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        (erasing && dq_oe) |-> (dq_out[7] == 1'b0)); // R3
    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> (dq_out[5:0] == 6'd0)); // R3

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_wa(mem_wa),
    .mem_wd(mem_wd), .mem_old(mem_old), .erasing(erasing), .busy(busy),
    .susp(susp), .esel(esel), .sect_prot(sect_prot), .dq_oe(dq_oe),
    .dq_out(dq_out)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
// Bench for flash_cmd_ctrl: keeps a byte-level shadow of the array,
// drives bus cycles through tasks and sweeps the whole array after each
// operation. Sector bounds are computed from the unit sizes.
module flash_cmd_ctrl_tb_top;

    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int UNIT   = DEPTH / 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [6:0]        sect_prot = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mdl [DEPTH];

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(8), .ERASE_WIN(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .sect_prot(sect_prot),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung");
        finish_run();
    end

    function automatic int sect_of(int idx);
        int sizes[7] = '{8, 8, 8, 4, 1, 1, 2};
        int lim = 0;
        for (int s = 0; s < 7; s++) begin
            lim += sizes[s] * UNIT;
            if (idx < lim) return s;
        end
        return 6;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        @(negedge clk); addr = ADDR_W'(a); dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_rd(input int a, output logic [7:0] v);
        @(negedge clk); addr = ADDR_W'(a); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dq_out;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic unlock();
        bus_wr('h555, 8'hAA);
        bus_wr('h2AA, 8'h55);
    endtask

    task automatic prog4(input int a, input logic [7:0] d);
        unlock();
        bus_wr('h555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_wr('h555, 8'h80);
        unlock();
    endtask

    task automatic wait_done(input int a);
        logic [7:0] v1, v2;
        for (int i = 0; i < 6000; i++) begin
            bus_rd(a, v1);
            bus_rd(a, v2);
            if (v1 == v2) break;
        end
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            bus_rd(i, v);
            chk(v == mdl[i], tag, v, mdl[i]);
        end
    endtask

    task automatic model_erase(input logic [6:0] sel);
        for (int i = 0; i < DEPTH; i++)
            if (sel[sect_of(i)]) mdl[i] = 8'hFF;
    endtask

    initial begin
        logic [7:0] v, w;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: erased array after reset, read enable
        @(negedge clk); addr = '0; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); chk(dq_oe == 1'b1, "R1 dq_oe", dq_oe, 1);
        oe_n = 1'b1; ce_n = 1'b1;
        sweep("R1 reset sweep");

        // R2 and R3: four-write program with status polling
        prog4(5, 8'h3C);
        bus_rd(5, v); bus_rd(5, w);
        chk(v[7] == 1'b1 && v[5:0] == 6'd0, "R3 prog status", v, 8'h80);
        chk(v[6] != w[6], "R3 toggle", w, {v[7], ~v[6], 6'd0});
        wait_done(5); mdl[5] = 8'h3C;
        bus_rd(5, v); chk(v == 8'h3C, "R2 program", v, 8'h3C);
        prog4(5, 8'hF0);
        bus_rd(5, v);
        chk(v[7] == 1'b0, "R3 prog bit7 of 0xF0", v, 8'h40);
        wait_done(5); mdl[5] = 8'h30;
        bus_rd(5, v); chk(v == 8'h30, "R2 and-only", v, 8'h30);

        // R4: broken sequence and reset command
        bus_wr('h555, 8'hAA); bus_wr('h2AA, 8'h12);
        bus_wr('h555, 8'hA0); bus_wr(5, 8'h00);
        bus_rd(5, v); chk(v == 8'h30, "R4 broken seq", v, 8'h30);
        unlock(); bus_wr('h555, 8'hF0);
        bus_wr(7, 8'h00);
        bus_rd(7, v); chk(v == 8'hFF, "R4 F0 abort", v, 8'hFF);

        // R5: bypass mode
        unlock(); bus_wr('h555, 8'h20);
        bus_wr('h20, 8'hA0); bus_wr('h40, 8'h77);
        wait_done('h40); mdl['h40] = 8'h77;
        bus_wr('h20, 8'hA0); bus_wr('h41, 8'h0F);
        wait_done('h41); mdl['h41] = 8'h0F;
        bus_rd('h40, v); chk(v == 8'h77, "R5 bypass prog a", v, 8'h77);
        bus_rd('h41, v); chk(v == 8'h0F, "R5 bypass prog b", v, 8'h0F);
        bus_wr(0, 8'hF0);
        bus_wr('h20, 8'hA0); bus_wr('h42, 8'h00);
        bus_rd('h42, v); bus_rd('h42, w);
        chk(v == 8'hFF && w == 8'hFF, "R5 after exit", v, 8'hFF);

        // R6: multi-sector erase at sector boundaries
        for (int k = 0; k < 5; k++) begin
            int a;
            a = (k == 0) ? 511 : (k == 1) ? 512 : (k == 2) ? 1919 : (k == 3) ? 1920 : 2047;
            prog4(a, 8'h5A); wait_done(a); mdl[a] = 8'h5A;
        end
        erase_prefix();
        bus_wr(100, 8'h30);
        bus_rd(3, v);
        chk(v[7] == 1'b0 && v[5:0] == 6'd0, "R3 erase status", v, 8'h00);
        bus_wr(2000, 8'h30);
        wait_done(3); model_erase(7'b1000001);
        sweep("R6 sector erase");

        // R8: protection against program and erase
        sect_prot = 7'b0000010;
        prog4(700, 8'h00);
        bus_rd(700, v); bus_rd(700, w);
        chk(v == 8'hFF && w == 8'hFF, "R8 prog protected", v, 8'hFF);
        sect_prot = 7'b0000000;
        prog4(700, 8'h81); wait_done(700); mdl[700] = 8'h81;
        prog4(1792, 8'h11); wait_done(1792); mdl[1792] = 8'h11;
        prog4(1855, 8'h12); wait_done(1855); mdl[1855] = 8'h12;
        prog4(1856, 8'h13); wait_done(1856); mdl[1856] = 8'h13;
        sect_prot = 7'b0000010;
        erase_prefix();
        bus_wr(700, 8'h30); bus_wr(1800, 8'h30);
        wait_done(0); model_erase(7'b0010000);
        sweep("R8 erase protected");
        sect_prot = 7'b0000000;

        // R9: suspend, side programs, resume
        prog4(1100, 8'h11); wait_done(1100); mdl[1100] = 8'h11;
        prog4(1600, 8'h22); wait_done(1600); mdl[1600] = 8'h22;
        erase_prefix();
        bus_wr(1100, 8'h30);
        repeat (60) @(negedge clk);
        bus_wr(0, 8'hB0);
        bus_rd(1600, v); chk(v == 8'h22, "R9 read other sector", v, 8'h22);
        bus_rd(1100, v); chk(v == 8'h80, "R9 read selected", v, 8'h80);
        prog4(1610, 8'h5A); wait_done(1610); mdl[1610] = 8'h5A;
        bus_rd(1610, v); chk(v == 8'h5A, "R9 program in suspend", v, 8'h5A);
        prog4(1110, 8'h00);
        bus_rd(1110, v); bus_rd(1110, w);
        chk(v == 8'h80 && w == 8'h80, "R9 selected program dropped", w, 8'h80);
        bus_wr(0, 8'h30);
        wait_done(1100); model_erase(7'b0000100);
        sweep("R9 after resume");

        // R7: whole-array erase with one protected sector
        sect_prot = 7'b0000010;
        erase_prefix();
        bus_wr('h555, 8'h10);
        wait_done(0); model_erase(7'b1111101);
        sweep("R7 chip erase");
        bus_rd(700, v); chk(v == 8'h81, "R7 protected kept", v, 8'h81);

        finish_run();
    end

endmodule